// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Timer

This block is a clocked monostable pulse generator. It watches three asynchronous control pins: a falling-edge trigger, a rising-edge trigger and an active-low clear. When a qualifying edge arrives it drives `pulse_out` high for a programmed number of clock cycles. Each trigger input only counts while the other inputs hold their enabling levels. A trigger that comes while the pulse is already running reloads the full count, so a steady train of triggers keeps the output high without a break. Holding the clear pin low ends any pulse and blocks every trigger. The clear pin's own rising edge also counts as a trigger when the two trigger pins are at their enabling levels.

The pulse length comes from a `WIDTH`-bit input, which is sampled at each trigger. A chip that needs two timers places two instances. All pins are synchronized inside the block, so the response to any pin change has a fixed latency.

Top module: `retrig_pulse_gen`

## Requirements
- R1: A falling edge on `trig_fall_n` starts a pulse only while `trig_rise` is high and `clr_n` is high. With `trig_rise` low the edge leaves `pulse_out` low.
- R2: A rising edge on `trig_rise` starts a pulse only while `trig_fall_n` is low and `clr_n` is high. With `trig_fall_n` high the edge leaves `pulse_out` low.
- R3: A rising edge on `clr_n` starts a pulse when `trig_fall_n` is low and `trig_rise` is high.
- R4: While `clr_n` is low, no trigger is accepted. `pulse_out` goes low on the third clock edge after `clr_n` falls, which ends any running pulse.
- R5: A trigger accepted while `pulse_out` is high reloads the full width, so the pulse lasts the programmed width counted from the last trigger.
- R6: Triggers that repeat faster than the programmed width keep `pulse_out` continuously high. This includes a trigger whose reload lands in the final cycle of the count.
- R7: After reset, `pulse_out_n` is always the complement of `pulse_out`.
- R8: `pulse_out` rises on the third clock edge after a qualifying pin change: two synchronizer stages plus one output register. It then stays high for exactly the programmed number of cycles.
- R9: `width` is captured when the trigger is accepted, so later changes do not affect the running pulse. A width of 0 gives a one-cycle pulse.
- R10: Reset is synchronous and active low. It sets `pulse_out` low and `pulse_out_n` high, clears the count, and cuts off a running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_fall_n | input | 1 | Asynchronous trigger, acts on falling edge |
| trig_rise | input | 1 | Asynchronous trigger, acts on rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; its rising edge may trigger |
| width | input | WIDTH | Pulse length in clock cycles, captured at each trigger |
| pulse_out | output | 1 | Pulse output |
| pulse_out_n | output | 1 | Complement of `pulse_out` |

## Verification
A retrigger can collide with the count running out. In that case the reload and the expiry fall on the same clock edge, and the reload must win. The bench times a second rising edge on `trig_rise` so that its reload lands on exactly the edge where a 5-cycle pulse would otherwise drop. It then checks that the high run is one unbroken stretch of 10 samples. It repeats the stimulus one cycle later and expects a single low sample between two pulses.

// File: rtl/rpg_pkg.sv
// Package rpg_pkg
// Shared definitions for the retriggerable pulse generator: the bit
// positions of the three control pins inside the synchronized vectors,
// and the struct that carries the detected edges.
// Assumes: all modules index pin vectors through these constants.
package rpg_pkg;

    localparam int NUM_PINS = 3;
    localparam int PIN_FALL = 0;   // falling-edge trigger pin
    localparam int PIN_RISE = 1;   // rising-edge trigger pin
    localparam int PIN_CLR  = 2;   // active-low clear pin

    // Reset levels of the synchronizers: the idle (non-triggering) levels,
    // with the clear pin released so no false clear edge is seen.
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b101;

    typedef struct packed {
        logic fall_edge;   // falling-edge pin went 1 -> 0
        logic rise_edge;   // rising-edge pin went 0 -> 1
        logic clr_edge;    // clear pin went 0 -> 1
    } edge_set_t;

endpackage

// File: rtl/rpg_input_sync.sv
// Module rpg_input_sync
// Brings N asynchronous pins into the clock domain through a chain of
// STAGES flops per pin. It also keeps one more flop holding the
// previous synchronized sample, so that edges can be found downstream.
// Assumes: STAGES >= 2; the reset levels are given per pin by RST_VAL.
module rpg_input_sync #(
    parameter int              N       = 3,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_async,
    output logic [N-1:0] lvl,
    output logic [N-1:0] lvl_prev
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              prev_r;

        // Shift the pin through the synchronizer and keep one older sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain  <= {STAGES{RST_VAL[g]}};
                prev_r <= RST_VAL[g];
            end else begin
                chain  <= {chain[LAST-1:0], pin_async[g]};
                prev_r <= chain[LAST];
            end
        end

        assign lvl[g]      = chain[LAST];
        assign lvl_prev[g] = prev_r;
    end

endmodule

// File: rtl/rpg_trigger_qual.sv
// Module rpg_trigger_qual
// Combinational gating of the trigger conditions. It finds the edges
// from the current and previous synchronized samples, and accepts an
// edge only when the other pins sit at their enabling levels.
// Assumes: inputs come from rpg_input_sync and are stable per cycle.
module rpg_trigger_qual
    import rpg_pkg::*;
(
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] lvl_prev,
    output edge_set_t           edges,
    output logic                fire,
    output logic                clr_active
);

    logic fall_lvl, rise_lvl, clr_lvl;

    // Name the synchronized levels.
    always_comb begin
        fall_lvl = lvl[PIN_FALL];
        rise_lvl = lvl[PIN_RISE];
        clr_lvl  = lvl[PIN_CLR];
    end

    // Edge detection from current versus previous sample.
    always_comb begin
        edges.fall_edge = !fall_lvl &&  lvl_prev[PIN_FALL];
        edges.rise_edge =  rise_lvl && !lvl_prev[PIN_RISE];
        edges.clr_edge  =  clr_lvl  && !lvl_prev[PIN_CLR];
    end

    // Gate each edge with the enabling levels of the other pins.
    always_comb begin
        fire = clr_lvl && (
                   (edges.fall_edge &&  rise_lvl) ||
                   (edges.rise_edge && !fall_lvl) ||
                   (edges.clr_edge  && !fall_lvl && rise_lvl));
        clr_active = !clr_lvl;
    end

endmodule

// File: rtl/rpg_pulse_timer.sv
// Module rpg_pulse_timer
// Down-counter that holds the output high for the captured width. A
// trigger reloads the full width, also in the last cycle of a count.
// A held clear drops the output and the count and wins over triggers.
// Assumes: fire and clear_hold come from the synchronized domain.
module rpg_pulse_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             clear_hold,
    input  logic [WIDTH-1:0] width_in,
    output logic             q,
    output logic             q_n
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] remain;
    logic [WIDTH-1:0] load_val;

    // A zero width is raised to the one-cycle minimum.
    always_comb begin
        load_val = (width_in == '0) ? ONE : width_in;
    end

    // Count down, reload on trigger, drop on clear, reset or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            q      <= 1'b0;
            q_n    <= 1'b1;
        end else if (clear_hold) begin
            remain <= '0;
            q      <= 1'b0;
            q_n    <= 1'b1;
        end else if (fire) begin
            remain <= load_val;
            q      <= 1'b1;
            q_n    <= 1'b0;
        end else if (q) begin
            if (remain == ONE) begin
                remain <= '0;
                q      <= 1'b0;
                q_n    <= 1'b1;
            end else begin
                remain <= remain - ONE;
            end
        end
    end

endmodule

// File: rtl/retrig_pulse_gen.sv
// Module retrig_pulse_gen (top)
// One retriggerable gated pulse channel. It synchronizes the three
// control pins, qualifies their edges and drives the timed pulse with
// its complement. Instantiate it twice for a dual timer.
// Assumes: the pins are asynchronous and width is static around triggers.
module retrig_pulse_gen
    import rpg_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fall_n,
    input  logic             trig_rise,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] width,
    output logic             pulse_out,
    output logic             pulse_out_n
);

    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] lvl_prev;
    edge_set_t           edges;
    logic                fire;
    logic                clr_active;

    // Gather the pins in package order.
    always_comb begin
        pins           = '0;
        pins[PIN_FALL] = trig_fall_n;
        pins[PIN_RISE] = trig_rise;
        pins[PIN_CLR]  = clr_n;
    end

    rpg_input_sync #(
        .N       (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pins),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev)
    );

    rpg_trigger_qual qual_i (
        .lvl        (lvl),
        .lvl_prev   (lvl_prev),
        .edges      (edges),
        .fire       (fire),
        .clr_active (clr_active)
    );

    rpg_pulse_timer #(
        .WIDTH (WIDTH)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .clear_hold (clr_active),
        .width_in   (width),
        .q          (pulse_out),
        .q_n        (pulse_out_n)
    );

endmodule

// File: rtl/retrig_pulse_gen_chk.sv
// Module retrig_pulse_gen_chk
// Property checker for retrig_pulse_gen, attached through bind below.
// It watches the output pair, the accepted trigger and the
// synchronized clear level.
module retrig_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic pulse_out,
    input logic pulse_out_n,
    input logic fire,
    input logic clr_active
);

    a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out != pulse_out_n);

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!pulse_out && pulse_out_n));

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |=> !pulse_out);

    a_r5_trigger_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse_out);

    a_r8_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(fire));

endmodule

bind retrig_pulse_gen retrig_pulse_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_out   (pulse_out),
    .pulse_out_n (pulse_out_n),
    .fire        (fire),
    .clr_active  (clr_active)
);

// File: tb/retrig_pulse_gen_tb_top.sv
module retrig_pulse_gen_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         trig_fall_n;
    logic         trig_rise;
    logic         clr_n;
    logic [W-1:0] width;
    logic         pulse_out;
    logic         pulse_out_n;

    int checks   = 0;
    int failures = 0;
    int idx, first_hi, last_hi, hi_cnt, comp_bad;

    always #2 clk = ~clk;

    retrig_pulse_gen #(.WIDTH(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_n (trig_fall_n),
        .trig_rise   (trig_rise),
        .clr_n       (clr_n),
        .width       (width),
        .pulse_out   (pulse_out),
        .pulse_out_n (pulse_out_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One sample at the falling edge, recorded into the current window.
    task automatic tick();
        @(negedge clk);
        idx++;
        if (pulse_out == pulse_out_n) comp_bad++;
        if (pulse_out) begin
            if (first_hi < 0) first_hi = idx;
            last_hi = idx;
            hi_cnt++;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic win_reset();
        idx = 0; first_hi = -1; last_hi = -1; hi_cnt = 0;
    endtask

    task automatic settle();
        for (int i = 0; i < 30; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; trig_fall_n = 1'b1; trig_rise = 1'b0; clr_n = 1'b1; width = '0;
        repeat (3) @(negedge clk);
        check("R10", "pulse_out in reset", int'(pulse_out), 0);
        check("R10", "pulse_out_n in reset", int'(pulse_out_n), 1);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_fall_trigger();
        width = 16'd6;
        win_reset(); trig_rise = 1'b1; ticks(10);
        check("R2", "rise edge with fall pin high, high count", hi_cnt, 0);
        win_reset(); trig_fall_n = 1'b0;
        ticks(4); width = 16'd2;                 // R9: change after capture
        ticks(16);
        check("R8", "fall trigger first high sample", first_hi, 3);
        check("R1", "fall trigger pulse length", hi_cnt, 6);
        check("R9", "width change mid pulse ignored", last_hi, 8);
        trig_fall_n = 1'b1; trig_rise = 1'b0; settle();
    endtask

    task automatic t_fall_gated();
        width = 16'd4;
        win_reset(); trig_fall_n = 1'b0; ticks(12);
        check("R1", "fall edge with rise pin low, high count", hi_cnt, 0);
        trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_rise_trigger();
        width = 16'd4;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(12);
        check("R8", "rise trigger first high sample", first_hi, 3);
        check("R2", "rise trigger pulse length", hi_cnt, 4);
        trig_rise = 1'b0; settle(); trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_clr_trigger();
        width = 16'd5;
        trig_fall_n = 1'b0; clr_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(12);
        check("R4", "rise edge under held clear, high count", hi_cnt, 0);
        win_reset(); clr_n = 1'b1; ticks(12);
        check("R3", "clear release trigger first high", first_hi, 3);
        check("R3", "clear release trigger length", hi_cnt, 5);
        trig_rise = 1'b0; settle(); trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_clear_cut();
        width = 16'd20;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(5);
        clr_n = 1'b0; ticks(10);
        trig_rise = 1'b0; ticks(2); trig_rise = 1'b1; ticks(8);
        check("R4", "clear cut last high sample", last_hi, 7);
        check("R4", "clear cut high count incl. blocked retrigger", hi_cnt, 5);
        trig_rise = 1'b0; ticks(2); clr_n = 1'b1; settle();
        trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_retrigger();
        width = 16'd10;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(3);
        trig_rise = 1'b0; ticks(3);
        trig_rise = 1'b1; ticks(25);
        check("R5", "retrigger last high sample", last_hi, 18);
        check("R5", "retrigger high count", hi_cnt, 16);
        trig_rise = 1'b0; settle(); trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_full_duty();
        width = 16'd8;
        trig_fall_n = 1'b0; settle();
        win_reset();
        for (int k = 0; k < 9; k++) begin
            trig_rise = 1'b1; ticks(3);
            trig_rise = 1'b0; ticks(3);
        end
        ticks(15);
        check("R6", "pulse train first high", first_hi, 3);
        check("R6", "pulse train last high", last_hi, 58);
        check("R6", "pulse train unbroken", hi_cnt, last_hi - first_hi + 1);
        trig_fall_n = 1'b1; settle();
    endtask

    // Reload landing on the expiry edge versus one cycle later.
    task automatic t_expiry_edge();
        width = 16'd5;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(3);
        trig_rise = 1'b0; ticks(2);
        trig_rise = 1'b1; ticks(15);
        check("R6", "reload on expiry edge last high", last_hi, 12);
        check("R6", "reload on expiry edge unbroken", hi_cnt, 10);
        trig_rise = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(3);
        trig_rise = 1'b0; ticks(3);
        trig_rise = 1'b1; ticks(15);
        check("R8", "late reload last high", last_hi, 13);
        check("R8", "late reload leaves one low gap", last_hi - first_hi + 1 - hi_cnt, 1);
        trig_rise = 1'b0; settle(); trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_zero_width();
        width = 16'd0;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(10);
        check("R9", "zero width first high", first_hi, 3);
        check("R9", "zero width gives one cycle", hi_cnt, 1);
        trig_rise = 1'b0; settle(); trig_fall_n = 1'b1; settle();
    endtask

    task automatic t_reset_mid();
        width = 16'd20;
        trig_fall_n = 1'b0; settle();
        win_reset(); trig_rise = 1'b1; ticks(5);
        rst_n = 1'b0; trig_rise = 1'b0; tick();
        check("R10", "reset mid pulse pulse_out", int'(pulse_out), 0);
        check("R10", "reset mid pulse pulse_out_n", int'(pulse_out_n), 1);
        rst_n = 1'b1; ticks(25);
        check("R10", "no pulse after reset release", last_hi, 5);
        trig_fall_n = 1'b1; settle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        comp_bad = 0;
        win_reset();
        t_reset();
        comp_bad = 0;
        t_fall_trigger();
        t_fall_gated();
        t_rise_trigger();
        t_clr_trigger();
        t_clear_cut();
        t_retrigger();
        t_full_duty();
        t_expiry_edge();
        t_zero_width();
        t_reset_mid();
        check("R7", "samples with outputs not complementary", comp_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule